// File: doc/BRIEF.md
# Branch Condition Unit

This unit makes the taken / not-taken call for the conditional branch instruction of a small 32-bit processor. The execute stage writes four condition flags into it: negative, zero, positive and carry-out. Compare and test are done as a subtract whose result goes to register 0 and is thrown away, so these flags still describe the last subtract. The unit holds the flags until the next update strobe.

When a branch instruction is presented with its valid strobe, the unit reads the 3-bit condition field and tests it against the stored flags. It then drives a taken signal and the next program counter. On a taken branch that value is the zero-extended address field of the instruction. Otherwise it is the current program counter plus one word. The decision and the next program counter are combinational from the stored flags, the instruction and the program counter. The only state is the flag register.

Top module: `branch_cond_unit`

## Requirements
- R1: After reset the stored flags are negative=0, zero=1, positive=0, carry=0. Before any flag update, a branch with condition 010 or 100 is taken and one with condition 001 or 111 is not.
- R2: `taken` is 0 whenever `br_valid` is 0, or when the opcode in `insn[31:27]` is not 01111.
- R3: Condition 000 (in `insn[26:24]`) is taken whatever the flags are.
- R4: Conditions 001, 010 and 111 are taken when negative, zero and positive are set, in that order. Conditions 101, 110 and 011 are taken when negative, zero and positive are clear, in that order.
- R5: Condition 100 is taken exactly when the stored carry flag is 0.
- R6: When `flag_wr` is high at a clock edge, the flags load `flag_neg`, `flag_zero`, `flag_pos` and `flag_carry`. When it is low, the flags keep their value whatever those inputs do.
- R7: A branch presented in the same cycle as a flag update is decided on the flags stored before that update.
- R8: On a taken branch, `next_pc` equals `insn[19:0]` zero-extended to 32 bits. Bits 23:20 of `insn` have no effect.
- R9: When not taken, `next_pc` is `pc + 1`, wrapping modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_wr | input | 1 | Flag update strobe |
| flag_neg | input | 1 | New negative flag |
| flag_zero | input | 1 | New zero flag |
| flag_pos | input | 1 | New positive flag |
| flag_carry | input | 1 | New carry-out flag |
| br_valid | input | 1 | Instruction word holds a candidate branch |
| insn | input | 32 | Instruction word |
| pc | input | 32 | Current program counter (word address) |
| taken | output | 1 | Branch is taken |
| next_pc | output | 32 | Program counter for the next fetch |

## Verification
The bench goes after these cases:
- **Reset values.** A design that cleared the zero flag on reset would skip an equal branch and take a not-zero branch before the first update.
- **Negated conditions.** Each condition is checked under several flag patterns, including patterns where none of the sign flags is set, so a swapped or un-negated test mis-branches.
- **Carry-clear polarity.** Condition 100 is checked with carry both 0 and 1, so a carry-set test shows up.
- **Update in the same cycle.** A branch is placed in the same cycle as a flag write. A design that bypassed the new flags would follow the wrong flags there.
- **Edge values.** Junk in bits 23:20 must stay out of the target, a non-branch opcode must never be taken, and `pc = 0xFFFFFFFF` must wrap to zero.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam int WORD_W = 32;
    localparam int OPC_W  = 5;
    localparam int CC_W   = 3;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 5'b01111;

    typedef enum logic [CC_W-1:0] {
        CC_ALWAYS = 3'd0,
        CC_NEG    = 3'd1,
        CC_ZERO   = 3'd2,
        CC_NPOS   = 3'd3,
        CC_NCARRY = 3'd4,
        CC_NNEG   = 3'd5,
        CC_NZERO  = 3'd6,
        CC_POS    = 3'd7
    } cc_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic pos;
        logic carry;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0, carry: 1'b0};

    function automatic logic cc_holds(cc_e cc, flags_t f);
        logic r;
        case (cc)
            CC_ALWAYS: r = 1'b1;
            CC_NEG:    r = f.neg;
            CC_ZERO:   r = f.zero;
            CC_NPOS:   r = ~f.pos;
            CC_NCARRY: r = ~f.carry;
            CC_NNEG:   r = ~f.neg;
            CC_NZERO:  r = ~f.zero;
            CC_POS:    r = f.pos;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcu_flag_reg.sv
module bcu_flag_reg
    import bcu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr,
    input  flags_t d,
    output flags_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= FLAGS_RESET;
        else if (wr)
            q <= d;
    end

    // R1: first cycle out of reset shows the reset pattern
    p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> q == FLAGS_RESET);

    // R6: a strobe loads the presented flags
    p_flag_load_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(wr) && !$past(rst)) |-> q == $past(d));

    // R6: no strobe, no change
    p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr) && !$past(rst)) |-> $stable(q));

endmodule

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
    import bcu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic [CC_W-1:0]  cc,
    input  flags_t           flags,
    output logic             taken
);

    logic is_branch;

    always_comb begin
        is_branch = valid && (opcode == OPC_BRANCH);
        taken     = is_branch && cc_holds(cc_e'(cc), flags);
    end

    // R2: no decision without a valid branch opcode
    p_gate_r2: assert property (@(posedge clk) disable iff (rst)
        taken |-> (valid && opcode == OPC_BRANCH));

    // R3: unconditional code never falls through
    p_always_r3: assert property (@(posedge clk) disable iff (rst)
        (valid && opcode == OPC_BRANCH && cc == 3'd0) |-> taken);

    // R5: carry-clear branch never taken with carry set
    p_ncarry_r5: assert property (@(posedge clk) disable iff (rst)
        (cc == 3'd4 && flags.carry) |-> !taken);

endmodule

// File: rtl/bcu_pc_sel.sv
module bcu_pc_sel #(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              taken,
    input  logic [ADDR_W-1:0] target,
    input  logic [PC_W-1:0]   pc,
    output logic [PC_W-1:0]   next_pc
);

    localparam int PAD_W = PC_W - ADDR_W;

    logic [PC_W-1:0] target_ext;
    logic [PC_W-1:0] pc_inc;

    always_comb begin
        target_ext = {{PAD_W{1'b0}}, target};
        pc_inc     = pc + PC_W'(1);
        next_pc    = taken ? target_ext : pc_inc;
    end

    // R8: a taken target never reaches above the address field
    p_target_zext_r8: assert property (@(posedge clk) disable iff (rst)
        taken |-> next_pc[PC_W-1:ADDR_W] == '0);

endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import bcu_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 20,
    parameter int CC_LSB  = 24,
    parameter int OPC_LSB = 27
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flag_wr,
    input  logic            flag_neg,
    input  logic            flag_zero,
    input  logic            flag_pos,
    input  logic            flag_carry,
    input  logic            br_valid,
    input  logic [WORD_W-1:0] insn,
    input  logic [PC_W-1:0] pc,
    output logic            taken,
    output logic [PC_W-1:0] next_pc
);

    localparam int GAP_W = CC_LSB - ADDR_W;

    flags_t flags_d;
    flags_t flags_q;
    logic   unused_gap;

    always_comb begin
        flags_d    = '{neg: flag_neg, zero: flag_zero, pos: flag_pos, carry: flag_carry};
        unused_gap = ^insn[CC_LSB-1 -: GAP_W];
    end

    bcu_flag_reg u_flags (
        .clk (clk),
        .rst (rst),
        .wr  (flag_wr),
        .d   (flags_d),
        .q   (flags_q)
    );

    bcu_cond_eval u_eval (
        .clk    (clk),
        .rst    (rst),
        .valid  (br_valid),
        .opcode (insn[OPC_LSB +: OPC_W]),
        .cc     (insn[CC_LSB +: CC_W]),
        .flags  (flags_q),
        .taken  (taken)
    );

    bcu_pc_sel #(.PC_W(PC_W), .ADDR_W(ADDR_W)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .taken   (taken),
        .target  (insn[ADDR_W-1:0]),
        .pc      (pc),
        .next_pc (next_pc)
    );

    // R9: fall-through advances by one word
    p_fall_through_r9: assert property (@(posedge clk) disable iff (rst)
        !taken |-> next_pc == pc + PC_W'(1));

endmodule

// File: tb/branch_cond_unit_tb.sv
module branch_cond_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        flag_wr, flag_neg, flag_zero, flag_pos, flag_carry;
    logic        br_valid;
    logic [31:0] insn, pc;
    logic        taken;
    logic [31:0] next_pc;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    bit m_n, m_z, m_p, m_c;

    always #5 clk = ~clk;

    branch_cond_unit dut_i (
        .clk(clk), .rst(rst), .flag_wr(flag_wr), .flag_neg(flag_neg),
        .flag_zero(flag_zero), .flag_pos(flag_pos), .flag_carry(flag_carry),
        .br_valid(br_valid), .insn(insn), .pc(pc),
        .taken(taken), .next_pc(next_pc)
    );

    function automatic logic [31:0] mk(logic [4:0] op, logic [2:0] cc,
                                       logic [3:0] gap, logic [19:0] addr);
        return {op, cc, gap, addr};
    endfunction

    function automatic bit model_cond(logic [2:0] cc);
        bit r;
        case (cc)
            3'd0: r = 1;
            3'd1: r = m_n;
            3'd2: r = m_z;
            3'd3: r = !m_p;
            3'd4: r = !m_c;
            3'd5: r = !m_n;
            3'd6: r = !m_z;
            default: r = m_p;
        endcase
        return r;
    endfunction

    task automatic step(bit we, bit n, bit z, bit p, bit c, bit v,
                        logic [31:0] ins, logic [31:0] pcv, string tag);
        bit exp_t;
        logic [31:0] exp_pc;
        flag_wr = we; flag_neg = n; flag_zero = z; flag_pos = p; flag_carry = c;
        br_valid = v; insn = ins; pc = pcv;
        #1;
        exp_t  = v && (ins[31:27] == 5'b01111) && model_cond(ins[26:24]);
        exp_pc = exp_t ? {12'h000, ins[19:0]} : pcv + 32'd1;
        n_cmp++;
        if (taken !== exp_t || next_pc !== exp_pc) begin
            n_bad++;
            $display("FAIL %s: taken=%0b next_pc=%h expected taken=%0b next_pc=%h",
                     tag, taken, next_pc, exp_t, exp_pc);
        end
        @(posedge clk);
        if (we) begin m_n = n; m_z = z; m_p = p; m_c = c; end
        @(negedge clk);
    endtask

    function automatic string cc_tag(logic [2:0] cc);
        return (cc == 3'd0) ? "R3" : (cc == 3'd4) ? "R5" : "R4";
    endfunction

    initial begin
        #2000000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; flag_wr = 1; flag_neg = 1; flag_zero = 0; flag_pos = 1; flag_carry = 1;
        br_valid = 0; insn = '0; pc = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        m_n = 0; m_z = 1; m_p = 0; m_c = 0;

        // R1: reset flag pattern observed through branches
        step(0,1,0,1,1, 1, mk(5'b01111, 3'd2, 4'h0, 20'h00010), 32'h100, "R1");
        step(0,1,0,1,1, 1, mk(5'b01111, 3'd4, 4'h0, 20'h00020), 32'h101, "R1");
        step(0,1,0,1,1, 1, mk(5'b01111, 3'd1, 4'h0, 20'h00030), 32'h102, "R1");
        step(0,1,0,1,1, 1, mk(5'b01111, 3'd7, 4'h0, 20'h00040), 32'h103, "R1");

        // R2: gating by valid and opcode
        step(0,0,0,0,0, 0, mk(5'b01111, 3'd0, 4'h0, 20'h00050), 32'h200, "R2");
        step(0,0,0,0,0, 1, mk(5'b01110, 3'd0, 4'h0, 20'h00060), 32'h201, "R2");
        step(0,0,0,0,0, 1, mk(5'b11111, 3'd0, 4'h0, 20'h00070), 32'h202, "R2");

        // R3 R4 R5: sweep all codes over several flag patterns
        for (int pat = 0; pat < 16; pat++) begin
            step(1, pat[3], pat[2], pat[1], pat[0], 0, 32'h0, 32'h300, "R6");
            for (int cc = 0; cc < 8; cc++)
                step(0, 0,0,0,0, 1, mk(5'b01111, 3'(cc), 4'h0, 20'(32'h1000 + pat*8 + cc)),
                     32'(32'h400 + cc), cc_tag(3'(cc)));
        end

        // R6: flags hold while inputs toggle with no strobe
        step(1, 0,0,1,0, 0, 32'h0, 32'h500, "R6");
        for (int k = 0; k < 4; k++)
            step(0, 1,1,0,1, 1, mk(5'b01111, 3'd7, 4'h0, 20'(k + 1)), 32'h510, "R6");
        step(0, 1,1,0,1, 1, mk(5'b01111, 3'd4, 4'h0, 20'h00abc), 32'h511, "R6");

        // R7: same-cycle update decided on old flags
        step(1, 0,1,0,0, 1, mk(5'b01111, 3'd7, 4'h0, 20'h00777), 32'h600, "R7");
        step(0, 0,0,0,0, 1, mk(5'b01111, 3'd2, 4'h0, 20'h00778), 32'h601, "R7");
        step(1, 1,0,0,1, 1, mk(5'b01111, 3'd2, 4'h0, 20'h00779), 32'h602, "R7");
        step(0, 0,0,0,0, 1, mk(5'b01111, 3'd1, 4'h0, 20'h0077a), 32'h603, "R7");

        // R8: address zero-extended, gap bits ignored
        step(0, 0,0,0,0, 1, mk(5'b01111, 3'd0, 4'hf, 20'hfffff), 32'h700, "R8");
        step(0, 0,0,0,0, 1, mk(5'b01111, 3'd0, 4'ha, 20'h00000), 32'h701, "R8");

        // R9: fall-through wrap
        step(0, 0,0,0,0, 1, mk(5'b01111, 3'd4, 4'h0, 20'h12345), 32'hffffffff, "R9");
        step(0, 0,0,0,0, 0, 32'h0, 32'hffffffff, "R9");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule